// File: doc/BRIEF.md
# SPI Potentiometer Command Frame Decoder

This block is the serial command front end of a dual 64-tap digitally controlled potentiometer. It acts as an SPI slave in mode 0. The serial clock, chip select and data input are sampled by a faster system clock, so their edges are found by oversampling. Each frame begins with an address byte. That byte has to carry the right type nibble, zeros in its two reserved bits, and a two-bit slave address equal to the strap pins. Only after that check passes is the second byte taken as an instruction, made up of an opcode, a data-register pointer and a wiper pointer.

Each potentiometer has one wiper register and four data registers, all 6 bits wide. The instruction byte can read or write a wiper, read or write a data register, or copy between a data register and the wiper of the same potentiometer. Writes take their value from a third byte. Reads shift the value out during a third byte. The two wiper values are driven out continuously to the tap selection logic. The serial output has a separate enable, so the pad can float when this device is not the one selected.

Top module: `spiPotFrameDecoder`

## Requirements
- R1: After reset, both wiper outputs and all eight data registers read 0, and `misoOe` is 0.
- R2: A frame is acted on only if its first byte has bits 7:4 = 4'b0101, bits 3:2 = 2'b00 and bits 1:0 equal to `addrPins`. If any of these differ, no register changes for the rest of the frame.
- R3: `misoOe` is 1 only while `csN` is low and the frame's address byte matched. Once set, it stays set until `csN` goes high.
- R4: Opcode 4'b1010 (instruction bits 7:4) writes bits 5:0 of the third byte into the wiper chosen by instruction bit 0. Only that wiper changes.
- R5: Opcode 4'b1001 shifts out the chosen wiper during the third byte as 2'b00 followed by the 6-bit value, MSB first. The first bit is valid before the first rising SCK edge of that byte.
- R6: Opcode 4'b1100 writes bits 5:0 of the third byte into data register DR[instruction bits 3:2] of the chosen potentiometer. Opcode 4'b1011 reads that register out in the format of R5.
- R7: Opcode 4'b1101 copies the chosen data register into the chosen wiper once the instruction byte completes. No third byte is needed.
- R8: Opcode 4'b1110 copies the chosen wiper into the chosen data register once the instruction byte completes.
- R9: An instruction byte whose opcode is not one of the six above, or whose bit 1 is 1, changes no register.
- R10: If `csN` goes high before a write frame's third byte is complete, the frame is aborted and no register changes. The next frame starts again from the address byte.
- R11: `misoData` changes during a frame only after a falling SCK edge. It returns to 0 when `csN` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial lines |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Active-low chip select; high aborts the frame |
| sck | input | 1 | Serial clock, mode 0 |
| mosi | input | 1 | Serial data in, MSB first |
| addrPins | input | 2 | Strapped slave address |
| misoData | output | 1 | Serial data out |
| misoOe | output | 1 | Output enable for the serial data pad |
| wiperTap0 | output | 6 | Wiper register of potentiometer 0 |
| wiperTap1 | output | 6 | Wiper register of potentiometer 1 |

## Verification
Directed frames first exercise each opcode once, with values that can be told apart. A write followed by a read shows whether the pointer bits reach the correct register, and the copies show whether the source and destination are swapped. Frames that are wrong in only one address field (type nibble, reserved bits or strap bits) isolate each part of the address match. Illegal opcodes, a set bit 1 and a frame cut short show that nothing is written. Random frames, about a quarter of them misaddressed, mix pointers and strap values, so a register-file indexing error surfaces in a later read.

// File: rtl/spiPotPkg.sv
package spiPotPkg;
  localparam int TapW    = 6;
  localparam int NumPots = 2;
  localparam int NumDr   = 4;
  localparam int ByteW   = 8;
  localparam int PotIdxW = $clog2(NumPots);
  localparam int DrIdxW  = $clog2(NumDr);
  localparam int BitCntW = $clog2(ByteW);

  typedef enum logic [3:0] {
    OP_RD_WIPER = 4'b1001,
    OP_WR_WIPER = 4'b1010,
    OP_RD_DATA  = 4'b1011,
    OP_WR_DATA  = 4'b1100,
    OP_CP_D2W   = 4'b1101,
    OP_CP_W2D   = 4'b1110
  } potOp_e;

  typedef enum logic [1:0] {
    ST_ADDR, ST_INSTR, ST_DATA, ST_SKIP
  } frameState_e;

  typedef struct packed {
    logic              wrWiper;
    logic              wrData;
    logic              cpyDtoW;
    logic              cpyWtoD;
    logic              ldRdWiper;
    logic              ldRdData;
    logic              shiftTx;
    logic              clrTx;
    logic [PotIdxW-1:0] pot;
    logic [DrIdxW-1:0]  dr;
    logic [TapW-1:0]    wdata;
  } ctrlStrobes_t;
endpackage

// File: rtl/spiPotCtrl.sv
module spiPotCtrl
  import spiPotPkg::*;
#(
  parameter logic [3:0] TypeId = 4'b0101
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         csN,
  input  logic         sck,
  input  logic         mosi,
  input  logic [1:0]   addrPins,
  output ctrlStrobes_t strobes,
  output logic         addrOk
);
  logic               sckQ;
  logic               sckRise, sckFall, byteDone, instrLegal, needsData;
  logic [ByteW-2:0]   shiftQ;
  logic [ByteW-1:0]   byteIn;
  logic [BitCntW-1:0] bitCnt;
  frameState_e        state;
  logic [3:0]         opQ;
  logic [PotIdxW-1:0] potQ;
  logic [DrIdxW-1:0]  drQ;

  assign sckRise    = ~csN & sck & ~sckQ;
  assign sckFall    = ~csN & ~sck & sckQ;
  assign byteIn     = {shiftQ, mosi};
  assign byteDone   = sckRise && (bitCnt == BitCntW'(ByteW - 1));
  assign instrLegal = (byteIn[1] == 1'b0);

  always_comb begin
    unique case (byteIn[7:4])
      OP_RD_WIPER, OP_WR_WIPER, OP_RD_DATA, OP_WR_DATA: needsData = 1'b1;
      default: needsData = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) sckQ <= 1'b0;
    else       sckQ <= sck;
  end

  always_ff @(posedge clk) begin
    if (!rstN || csN) begin
      state  <= ST_ADDR;
      bitCnt <= '0;
      shiftQ <= '0;
      addrOk <= 1'b0;
      opQ    <= '0;
      potQ   <= '0;
      drQ    <= '0;
    end else if (sckRise) begin
      bitCnt <= bitCnt + 1'b1;
      shiftQ <= byteIn[ByteW-2:0];
      if (byteDone) begin
        unique case (state)
          ST_ADDR: begin
            if (byteIn[7:4] == TypeId && byteIn[3:2] == 2'b00 && byteIn[1:0] == addrPins) begin
              addrOk <= 1'b1;
              state  <= ST_INSTR;
            end else begin
              state  <= ST_SKIP;
            end
          end
          ST_INSTR: begin
            opQ   <= byteIn[7:4];
            potQ  <= byteIn[PotIdxW-1:0];
            drQ   <= byteIn[3:2];
            state <= (instrLegal && needsData) ? ST_DATA : ST_SKIP;
          end
          default: state <= ST_SKIP;
        endcase
      end
    end
  end

  always_comb begin
    strobes         = '0;
    strobes.shiftTx = sckFall;
    strobes.clrTx   = csN;
    strobes.wdata   = byteIn[TapW-1:0];
    strobes.pot     = (state == ST_INSTR) ? byteIn[PotIdxW-1:0] : potQ;
    strobes.dr      = (state == ST_INSTR) ? byteIn[3:2] : drQ;
    if (byteDone && state == ST_INSTR && instrLegal) begin
      unique case (byteIn[7:4])
        OP_RD_WIPER: strobes.ldRdWiper = 1'b1;
        OP_RD_DATA:  strobes.ldRdData  = 1'b1;
        OP_CP_D2W:   strobes.cpyDtoW   = 1'b1;
        OP_CP_W2D:   strobes.cpyWtoD   = 1'b1;
        default: ;
      endcase
    end
    if (byteDone && state == ST_DATA) begin
      unique case (opQ)
        OP_WR_WIPER: strobes.wrWiper = 1'b1;
        OP_WR_DATA:  strobes.wrData  = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/spiPotRegs.sv
module spiPotRegs
  import spiPotPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  ctrlStrobes_t strobes,
  output logic         misoBit,
  output logic [TapW-1:0] wiperOut [NumPots]
);
  logic [TapW-1:0]  wiperQ [NumPots];
  logic [TapW-1:0]  dataQ  [NumPots][NumDr];
  logic [ByteW-1:0] txQ;

  for (genvar p = 0; p < NumPots; p++) begin : g_pot
    logic potHit;
    assign potHit      = (strobes.pot == PotIdxW'(p));
    assign wiperOut[p] = wiperQ[p];

    always_ff @(posedge clk) begin
      if (!rstN)                            wiperQ[p] <= '0;
      else if (strobes.wrWiper && potHit)   wiperQ[p] <= strobes.wdata;
      else if (strobes.cpyDtoW && potHit)   wiperQ[p] <= dataQ[p][strobes.dr];
    end

    for (genvar d = 0; d < NumDr; d++) begin : g_dr
      logic drHit;
      assign drHit = potHit && (strobes.dr == DrIdxW'(d));
      always_ff @(posedge clk) begin
        if (!rstN)                          dataQ[p][d] <= '0;
        else if (strobes.wrData && drHit)   dataQ[p][d] <= strobes.wdata;
        else if (strobes.cpyWtoD && drHit)  dataQ[p][d] <= wiperQ[p];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.clrTx) begin
      txQ     <= '0;
      misoBit <= 1'b0;
    end else if (strobes.ldRdWiper) begin
      txQ <= {{(ByteW-TapW){1'b0}}, wiperQ[strobes.pot]};
    end else if (strobes.ldRdData) begin
      txQ <= {{(ByteW-TapW){1'b0}}, dataQ[strobes.pot][strobes.dr]};
    end else if (strobes.shiftTx) begin
      misoBit <= txQ[ByteW-1];
      txQ     <= {txQ[ByteW-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/spiPotFrameDecoder.sv
module spiPotFrameDecoder
  import spiPotPkg::*;
#(
  parameter logic [3:0] TypeId = 4'b0101
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            csN,
  input  logic            sck,
  input  logic            mosi,
  input  logic [1:0]      addrPins,
  output logic            misoData,
  output logic            misoOe,
  output logic [TapW-1:0] wiperTap0,
  output logic [TapW-1:0] wiperTap1
);
  ctrlStrobes_t    strobes;
  logic            addrOk;
  logic [TapW-1:0] wiperOut [NumPots];

  spiPotCtrl #(.TypeId(TypeId)) ctrl_i (
    .clk, .rstN, .csN, .sck, .mosi, .addrPins,
    .strobes(strobes), .addrOk(addrOk)
  );

  spiPotRegs regs_i (
    .clk, .rstN, .strobes(strobes),
    .misoBit(misoData), .wiperOut(wiperOut)
  );

  assign misoOe    = ~csN & addrOk;
  assign wiperTap0 = wiperOut[0];
  assign wiperTap1 = wiperOut[1];
endmodule

// File: rtl/spiPotChecker.sv
module spiPotChecker
  import spiPotPkg::*;
(
  input logic            clk,
  input logic            rstN,
  input logic            csN,
  input logic            sck,
  input logic            misoData,
  input logic            misoOe,
  input logic [TapW-1:0] wiperTap0,
  input logic [TapW-1:0] wiperTap1
);
  p_oe_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !misoOe);

  p_oe_held_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && $past(!csN) && $past(misoOe)) |-> misoOe);

  p_wiper_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN)) |-> ($stable(wiperTap0) && $stable(wiperTap1)));

  p_single_wiper_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(!$stable(wiperTap0) && !$stable(wiperTap1)));

  p_miso_on_fall_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(misoData) && !$past(csN)) |-> (!$past(sck) && $past(sck, 2)));

  p_miso_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    ($past(csN) && csN) |-> !misoData);
endmodule

bind spiPotFrameDecoder spiPotChecker chk_i (.*);

// File: tb/spiPotFrameDecoder_tb.sv
module spiPotFrameDecoder_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       csN = 1'b1;
  logic       sck = 1'b0;
  logic       mosi = 1'b0;
  logic [1:0] addrPins = 2'b10;
  logic       misoData, misoOe;
  logic [5:0] wiperTap0, wiperTap1;

  int  nTests = 0;
  int  nFails = 0;
  bit  finished = 1'b0;

  logic [5:0] mW [2];
  logic [5:0] mD [2][4];

  always #4 clk = ~clk;

  spiPotFrameDecoder dut_i (
    .clk, .rstN, .csN, .sck, .mosi, .addrPins,
    .misoData, .misoOe, .wiperTap0, .wiperTap1
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nTests++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // returns expected read byte; expOe, isRead via outputs; updates model
  task automatic model(input logic [7:0] a, input logic [7:0] ins, input logic [7:0] d,
                       output logic expOe, output logic isRead, output logic [7:0] expRx);
    logic [3:0] op;
    logic       p;
    logic [1:0] r;
    expOe = 1'b0; isRead = 1'b0; expRx = 8'h00;
    if (a[7:4] != 4'b0101 || a[3:2] != 2'b00 || a[1:0] != addrPins) return;
    expOe = 1'b1;
    if (ins[1]) return;
    op = ins[7:4]; p = ins[0]; r = ins[3:2];
    case (op)
      4'b1001: begin isRead = 1'b1; expRx = {2'b00, mW[p]}; end
      4'b1010: mW[p] = d[5:0];
      4'b1011: begin isRead = 1'b1; expRx = {2'b00, mD[p][r]}; end
      4'b1100: mD[p][r] = d[5:0];
      4'b1101: mW[p] = mD[p][r];
      4'b1110: mD[p][r] = mW[p];
      default: ;
    endcase
  endtask

  task automatic xferByte(input logic [7:0] tx, output logic [7:0] rx, output logic oe);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk) mosi = tx[i];
      repeat (4) @(negedge clk);
      rx[i] = misoData;
      if (i == 4) oe = misoOe;
      sck = 1'b1;
      repeat (4) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic runFrame(input string req, input logic [7:0] a, input logic [7:0] ins,
                          input logic [7:0] d);
    logic       expOe, isRead, oe0, oe1, oe2;
    logic [7:0] expRx, rx0, rx1, rx2;
    model(a, ins, d, expOe, isRead, expRx);
    @(negedge clk) csN = 1'b0;
    repeat (4) @(negedge clk);
    xferByte(a, rx0, oe0);
    xferByte(ins, rx1, oe1);
    xferByte(d, rx2, oe2);
    check({req, " misoOe (R3)"}, {7'd0, oe2}, {7'd0, expOe});
    if (isRead) check({req, " read byte"}, rx2, expRx);
    repeat (4) @(negedge clk);
    csN = 1'b1;
    repeat (6) @(negedge clk);
    check({req, " misoOe idle (R3)"}, {7'd0, misoOe}, 8'h00);
    check({req, " wiper0"}, {2'b00, wiperTap0}, {2'b00, mW[0]});
    check({req, " wiper1"}, {2'b00, wiperTap1}, {2'b00, mW[1]});
  endtask

  function automatic logic [7:0] addrByte(input logic [1:0] pins);
    return {4'b0101, 2'b00, pins};
  endfunction

  initial begin
    int cyc = 0;
    while (!finished) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        nFails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", nTests, nFails);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] dummy, a, ins, d;
    logic       oeD;
    for (int p = 0; p < 2; p++) begin
      mW[p] = '0;
      for (int r = 0; r < 4; r++) mD[p][r] = '0;
    end
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1 wiper0", {2'b00, wiperTap0}, 8'h00);
    check("R1 wiper1", {2'b00, wiperTap1}, 8'h00);
    check("R1 misoOe", {7'd0, misoOe}, 8'h00);
    runFrame("R1 read DR3 pot1", addrByte(2'b10), 8'b1011_1101, 8'h00);

    // directed
    runFrame("R4 write wiper0", addrByte(2'b10), 8'b1010_0000, 8'hEA);
    runFrame("R5 read wiper0", addrByte(2'b10), 8'b1001_0000, 8'h00);
    runFrame("R6 write DR2 pot1", addrByte(2'b10), 8'b1100_1001, 8'h15);
    runFrame("R6 read DR2 pot1", addrByte(2'b10), 8'b1011_1001, 8'h00);
    runFrame("R6 read DR1 pot1", addrByte(2'b10), 8'b1011_0101, 8'h00);
    runFrame("R7 copy DR2 to wiper1", addrByte(2'b10), 8'b1101_1001, 8'h00);
    runFrame("R4 write wiper0 max", addrByte(2'b10), 8'b1010_0000, 8'h3F);
    runFrame("R8 copy wiper0 to DR3", addrByte(2'b10), 8'b1110_1100, 8'h00);
    runFrame("R8 read DR3 pot0", addrByte(2'b10), 8'b1011_1100, 8'h00);
    runFrame("R2 bad type nibble", 8'b0111_0010, 8'b1010_0000, 8'h11);
    runFrame("R2 bad strap bits", addrByte(2'b01), 8'b1010_0001, 8'h22);
    runFrame("R2 reserved bits set", 8'b0101_0110, 8'b1010_0001, 8'h23);
    runFrame("R9 undefined opcode", addrByte(2'b10), 8'b0111_0001, 8'h24);
    runFrame("R9 instruction bit1 set", addrByte(2'b10), 8'b1010_0011, 8'h25);
    runFrame("R9 wiper0 after illegal", addrByte(2'b10), 8'b1001_0000, 8'h00);

    // R10 abort mid write
    @(negedge clk) csN = 1'b0;
    repeat (4) @(negedge clk);
    xferByte(addrByte(2'b10), dummy, oeD);
    xferByte(8'b1010_0001, dummy, oeD);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk) mosi = 1'b1;
      repeat (4) @(negedge clk);
      sck = 1'b1;
      repeat (4) @(negedge clk);
      sck = 1'b0;
    end
    repeat (4) @(negedge clk);
    csN = 1'b1;
    repeat (6) @(negedge clk);
    check("R10 abort wiper1", {2'b00, wiperTap1}, {2'b00, mW[1]});
    check("R10 abort misoOe", {7'd0, misoOe}, 8'h00);
    runFrame("R10 frame after abort", addrByte(2'b10), 8'b1010_0001, 8'h2C);

    // random frames
    void'($urandom(32'd1234));
    for (int n = 0; n < 90; n++) begin
      logic [3:0] op;
      if ($urandom_range(0, 7) == 0) addrPins = 2'($urandom);
      a = addrByte(addrPins);
      if ($urandom_range(0, 3) == 0) a = 8'($urandom);
      op = 4'($urandom_range(9, 14));
      if ($urandom_range(0, 9) == 0) op = 4'($urandom);
      ins = {op, 2'($urandom), ($urandom_range(0, 9) == 0), 1'($urandom)};
      d = 8'($urandom);
      runFrame("R2/R4/R5/R6/R7/R8 random", a, ins, d);
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end
endmodule